// File: doc/BRIEF.md
# Saturating DSP Arithmetic Unit

A purely combinational datapath that performs the signed fixed-point operations a small DSP extension needs. It can do a saturating add or subtract. It can do a saturating add or subtract whose second operand is doubled first. It can do a signed 16x16 halfword multiply or a signed 32x16 multiply that keeps the upper 32 bits, and either multiply can optionally accumulate into a 32-bit value.

The unit holds no state. Whenever an operation detects signed overflow, it raises a one-bit request to set a sticky overflow flag. The surrounding core owns that flag, ORs this request into it and never clears it because of these operations. The result and the request depend only on the present inputs, so the unit sits inside a single execute stage.

Top module: `sat_dsp_alu`

## Requirements
- R1: Op code 0 returns the signed sum a+b. When that sum overflows 32 bits, the result saturates and q_set_o is 1; otherwise q_set_o is 0.
- R2: Op code 1 returns the signed difference a−b. When that difference overflows 32 bits, the result saturates and q_set_o is 1; otherwise q_set_o is 0.
- R3: A saturated result is 0x7FFFFFFF when the exact result is positive and 0x80000000 when it is negative.
- R4: Op code 2 returns a + 2b and op code 3 returns a − 2b. The doubling of b saturates on its own overflow, and the add or subtract then uses that saturated value.
- R5: For op codes 2 and 3, q_set_o is the OR of the doubling overflow and the add/subtract overflow.
- R6: Op code 4 multiplies two signed halfwords. sel_a_i=1 takes bits 31:16 of a and sel_a_i=0 takes bits 15:0. sel_b_i chooses the half of b in the same way.
- R7: Op code 5 multiplies all 32 bits of a, as a signed value, by the signed half of b that sel_b_i chooses. It returns bits 47:16 of the 48-bit product and ignores sel_a_i.
- R8: For op codes 4 and 5 with acc_en_i=1, the result is product + acc_i wrapped to 32 bits and never saturated. q_set_o is 1 exactly when that signed addition overflows.
- R9: For op codes 4 and 5 with acc_en_i=0, the result is the product alone and q_set_o is 0.
- R10: Op codes 6 and 7 give a result of 0 and q_set_o of 0.
- R11: acc_i and acc_en_i have no effect on op codes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (0 qadd, 1 qsub, 2 qdadd, 3 qdsub, 4 mul16, 5 mul32x16) |
| opa_i | input | 32 | First operand a |
| opb_i | input | 32 | Second operand b |
| acc_i | input | 32 | Accumulator addend |
| sel_a_i | input | 1 | Upper-half select for a (mul16) |
| sel_b_i | input | 1 | Upper-half select for b (mul16, mul32x16) |
| acc_en_i | input | 1 | Add acc_i to the multiply product |
| result_o | output | 32 | Operation result |
| q_set_o | output | 1 | Request to set the sticky overflow flag |

## Verification
Because the unit holds no state, any fault appears at the ports in the same evaluation. A wrong clamp shows as a saturated value with the wrong sign. A missed doubling overflow shows as a dropped q_set_o even when the final add is in range. A wrong product slice shows as a result off by a factor of 2^16 or with a flipped sign. The directed vectors drive the operands at the sign and range boundaries where these faults differ from correct behaviour. The random vectors cover the remaining operand space.

// File: rtl/sat_dsp_alu.sv
module sat_dsp_alu #(
  parameter int W = 32
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [W-1:0] acc_i,
  input  logic         sel_a_i,
  input  logic         sel_b_i,
  input  logic         acc_en_i,
  output logic [W-1:0] result_o,
  output logic         q_set_o
);

  localparam int HW = W / 2;
  localparam int PW = W + HW;
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  localparam logic [2:0] OP_QADD  = 3'd0;
  localparam logic [2:0] OP_QSUB  = 3'd1;
  localparam logic [2:0] OP_QDADD = 3'd2;
  localparam logic [2:0] OP_QDSUB = 3'd3;
  localparam logic [2:0] OP_MUL16 = 3'd4;
  localparam logic [2:0] OP_MULWH = 3'd5;

  logic         is_sat, is_dbl, is_sub, is_mul;
  logic         dbl_ovf, as_ovf, acc_ovf;
  logic [W-1:0] dbl_val, b_eff, as_raw, as_res;
  logic [HW-1:0] half_a, half_b;
  logic [W-1:0] p16;
  logic [PW-1:0] pwide;
  logic [W-1:0] prod, acc_sum;

  assign is_sat = (op_i[2] == 1'b0);
  assign is_dbl = is_sat && op_i[1];
  assign is_sub = op_i[0];
  assign is_mul = (op_i == OP_MUL16) || (op_i == OP_MULWH);

  assign dbl_ovf = opb_i[W-1] ^ opb_i[W-2];
  assign dbl_val = dbl_ovf ? (opb_i[W-1] ? MINV : MAXV) : {opb_i[W-2:0], 1'b0};
  assign b_eff   = is_dbl ? dbl_val : opb_i;

  assign as_raw = is_sub ? (opa_i - b_eff) : (opa_i + b_eff);
  assign as_ovf = is_sub ? ((opa_i[W-1] != b_eff[W-1]) && (as_raw[W-1] != opa_i[W-1]))
                         : ((opa_i[W-1] == b_eff[W-1]) && (as_raw[W-1] != opa_i[W-1]));
  assign as_res = as_ovf ? (opa_i[W-1] ? MINV : MAXV) : as_raw;

  assign half_a = sel_a_i ? opa_i[W-1:HW] : opa_i[HW-1:0];
  assign half_b = sel_b_i ? opb_i[W-1:HW] : opb_i[HW-1:0];
  assign p16    = W'($signed(half_a) * $signed(half_b));
  assign pwide  = PW'($signed(opa_i) * $signed(half_b));
  assign prod   = (op_i == OP_MUL16) ? p16 : pwide[PW-1:HW];

  assign acc_sum = prod + acc_i;
  assign acc_ovf = (prod[W-1] == acc_i[W-1]) && (acc_sum[W-1] != prod[W-1]);

  always_comb begin
    result_o = '0;
    q_set_o  = 1'b0;
    if (is_sat) begin
      result_o = as_res;
      q_set_o  = as_ovf || (is_dbl && dbl_ovf);
    end else if (is_mul) begin
      result_o = acc_en_i ? acc_sum : prod;
      q_set_o  = acc_en_i && acc_ovf;
    end
  end

  always_comb begin
    if ((op_i == OP_QADD || op_i == OP_QSUB) && q_set_o)
      AST_SAT_CLAMP: assert (result_o == MAXV || result_o == MINV) else $error("clamp value"); // R3
    if (op_i == OP_QADD && q_set_o)
      AST_SAT_SIGN: assert (result_o == (opa_i[W-1] ? MINV : MAXV)) else $error("clamp sign"); // R1
    if (is_mul && !acc_en_i)
      AST_MUL_NO_Q: assert (!q_set_o) else $error("q without accumulate"); // R9
    if (op_i[2:1] == 2'b11)
      AST_UNUSED_OP: assert (result_o == '0 && !q_set_o) else $error("unused op"); // R10
    if (op_i == OP_QDADD && !opb_i[W-1] && opb_i[W-2] && !opa_i[W-1])
      AST_DBL_POS_SAT: assert (q_set_o && result_o == MAXV) else $error("doubled sat"); // R5
  end

endmodule

// File: tb/sat_dsp_alu_tb.sv
module sat_dsp_alu_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]  op;
  logic [31:0] a, b, acc, res;
  logic        sa, sb, ae, q;
  int checks = 0, fails = 0;

  sat_dsp_alu dut_i (.op_i(op), .opa_i(a), .opb_i(b), .acc_i(acc), .sel_a_i(sa),
                     .sel_b_i(sb), .acc_en_i(ae), .result_o(res), .q_set_o(q));

  function automatic logic [32:0] clamp(longint v);
    if (v > 64'sd2147483647)       return {1'b1, 32'h7FFF_FFFF};
    else if (v < -64'sd2147483648) return {1'b1, 32'h8000_0000};
    return {1'b0, 32'(v)};
  endfunction

  function automatic logic [32:0] model(logic [2:0] o, logic [31:0] x, logic [31:0] y,
                                        logic [31:0] c, logic s1, logic s2, logic en);
    longint lx = longint'($signed(x));
    longint ly = longint'($signed(y));
    logic [32:0] d, r;
    longint p, s;
    logic [15:0] hx, hy;
    hx = s1 ? x[31:16] : x[15:0];
    hy = s2 ? y[31:16] : y[15:0];
    case (o)
      3'd0: return clamp(lx + ly);
      3'd1: return clamp(lx - ly);
      3'd2, 3'd3: begin
        d = clamp(2 * ly);
        if (o == 3'd2) r = clamp(lx + longint'($signed(d[31:0])));
        else           r = clamp(lx - longint'($signed(d[31:0])));
        return {d[32] | r[32], r[31:0]};
      end
      3'd4, 3'd5: begin
        if (o == 3'd4) p = longint'($signed(hx)) * longint'($signed(hy));
        else           p = (lx * longint'($signed(hy))) >>> 16;
        p = longint'($signed(p[31:0]));
        if (!en) return {1'b0, p[31:0]};
        s = p + longint'($signed(c));
        return {(s > 64'sd2147483647) || (s < -64'sd2147483648), s[31:0]};
      end
      default: return 33'd0;
    endcase
  endfunction

  task automatic apply(logic [2:0] o, logic [31:0] x, logic [31:0] y, logic [31:0] c,
                       logic s1, logic s2, logic en, string tag);
    logic [32:0] e;
    op = o; a = x; b = y; acc = c; sa = s1; sb = s2; ae = en;
    @(negedge clk);
    e = model(o, x, y, c, s1, s2, en);
    checks++;
    if ({q, res} !== e) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h acc=%h: got q=%b r=%h exp q=%b r=%h",
               tag, o, x, y, c, q, res, e[32], e[31:0]);
    end
  endtask

  task automatic expect_eq(logic [32:0] got, logic [32:0] exp, string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [32:0] ref_out;
    void'($urandom(32'd1234));
    op = 0; a = 0; b = 0; acc = 0; sa = 0; sb = 0; ae = 0;
    @(negedge clk);
    expect_eq({q, res}, 33'd0, "R1 idle zero");
    apply(0, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, "R1 R3 pos sat");
    apply(0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0, 0, "R1 R3 neg sat");
    apply(0, 32'h7FFF_FFFE, 32'h1, 0, 0, 0, 0, "R1 edge no sat");
    apply(1, 32'h8000_0000, 32'h1, 0, 0, 0, 0, "R2 R3 neg sat");
    apply(1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, "R2 R3 pos sat");
    apply(1, 32'h0, 32'h8000_0000, 0, 0, 0, 0, "R2 zero minus min");
    apply(2, 32'h0, 32'h4000_0000, 0, 0, 0, 0, "R4 R5 dbl sat only");
    apply(2, 32'hC000_0000, 32'h4000_0000, 0, 0, 0, 0, "R4 R5 dbl sat then fits");
    apply(3, 32'h0, 32'hC000_0000, 0, 0, 0, 0, "R4 R5 dbl neg sat");
    apply(3, 32'h1000_0000, 32'h2000_0000, 0, 0, 0, 0, "R4 no sat");
    apply(4, 32'h8000_0003, 32'h0005_8000, 0, 1, 1, 0, "R6 top halves");
    apply(4, 32'h8000_8000, 32'h0005_8000, 0, 0, 0, 0, "R6 min times min");
    apply(5, 32'h7FFF_FFFF, 32'h7FFF_0000, 0, 0, 1, 0, "R7 wide top");
    apply(5, 32'h8000_0000, 32'h0000_8000, 0, 1, 0, 0, "R7 wide neg");
    apply(4, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 0, 1, "R8 acc wrap");
    apply(5, 32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000, 0, 0, 1, "R8 acc neg wrap");
    apply(4, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 0, 0, "R9 no acc");
    apply(6, 32'h7FFF_FFFF, 32'h1, 32'h1, 1, 1, 1, "R10 op6");
    apply(7, 32'h8000_0000, 32'h8000_0000, 32'h1, 0, 0, 1, "R10 op7");
    for (int k = 0; k < 4; k++) begin
      apply(3'(k), 32'h7FFF_0000, 32'h7000_0000, 32'h0, 0, 0, 0, "R11 base");
      ref_out = {q, res};
      op = 3'(k); acc = 32'hDEAD_BEEF; ae = 1;
      @(negedge clk);
      expect_eq({q, res}, ref_out, "R11 acc ignored");
    end
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] x, y;
      x = $urandom();
      y = $urandom();
      if (n % 5 == 0) x = {x[31], {31{~x[31]}}} ^ 32'($urandom_range(0, 3));
      if (n % 7 == 0) y = {y[31], ~y[31], y[29:0]};
      apply(3'($urandom_range(0, 7)), x, y, $urandom(), 1'($urandom()), 1'($urandom()),
            1'($urandom()), "R1 R2 R4 R6 R7 R8 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule